// File: doc/BRIEF.md
# Encoder Control-Data Register Sequencer

This block performs register reads and writes on an absolute position encoder through the slow control-data side channel of a BiSS-C link. That channel moves a single bit in each position frame. The host gives an address, a direction flag and, for a write, one data byte. The block waits until the link has been quiet long enough. It then sends a 32-bit command, one bit per frame, and gathers the slave's reply one bit per frame.

Each command bit is driven as the clock-line level during the timeout that follows a frame. The level is the inverse of the bit. The neighbouring frame engine pulses `frame_stb` once at the end of every frame. With that pulse it presents the control-data bit it sampled from the slave on `cds_in`.

After 32 reply bits the block checks the echoed handshake field. A good read returns its data byte with a one-cycle `done`. A failure, including a slave that never answers, raises `err` together with `done`.

Top module: `cd_reg_seq`

## Requirements
- R1: After reset `clk_idle_lvl` is 1 and `busy`, `done` and `err` are 0.
- R2: `clk_idle_lvl` changes only on the clock edge that samples `frame_stb` high. Between strobes it holds, so one command bit is sent per frame.
- R3: While no command is being sent, `clk_idle_lvl` stays 1, which means the command bit is 0.
- R4: The first command bit goes out on the first strobe that comes after at least 14 strobes with a command bit of 0. These quiet strobes are counted since reset or since the end of the last command. If 14 or more have already passed when a request arrives, the command starts on the next strobe.
- R5: The command word is 32 bits long and is sent MSB first, so each bit appears as the inverse of `clk_idle_lvl`. Its fields, from bit 31 down:
  - start = 1
  - CTS = 1
  - slave ID = 0 (3 bits)
  - address (7 bits)
  - header CRC (4 bits)
  - R, then W, then S = 1
  - data (8 bits, 0 for a read)
  - payload CRC (4 bits)
  - stop = 0

  R,W is 1,0 for a read and 0,1 for a write. There is no extra leading 0 bit before the start bit.
- R6: Each CRC uses x^4+x+1, starts from 0, is computed MSB first and is sent inverted. The header CRC covers ID and address (10 bits). The payload CRC covers R, W, S and data (11 bits).
- R7: Reply bits are collected on the 32 strobes after the start-bit strobe. The first of them becomes bit 31 of the reply word. The last of these strobes ends the command, sets the line back to 1 and pulses `done` for one cycle.
- R8: The handshake is bits 14:12 of the reply word. A value of 3 acknowledges a write and 5 acknowledges a read. Either match gives `done` with `err` = 0.
- R9: Any other handshake value, including an all-zero reply, gives `done` with `err` = 1.
- R10: On an acknowledged read, `rd_data` takes reply bits 11:4 in the `done` cycle. Writes and failures leave `rd_data` unchanged.
- R11: A request is taken only when `busy` is 0. `busy` stays 1 from acceptance to the `done` cycle. A request made while busy does not alter the command being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse at the end of each position frame |
| cds_in | input | 1 | Slave control-data bit of the frame just ended |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Write data |
| clk_idle_lvl | output | 1 | Clock-line level for the timeout (inverse of the command bit) |
| busy | output | 1 | Request held or command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with `done` |
| rd_data | output | 8 | Last data byte read |

## Verification
A wrong bit index or a wrong quiet count shows up at once on `clk_idle_lvl`. The bench rebuilds the full 32-bit command from the line level and compares it bit for bit, and it also checks on which strobe the start bit appears. A fault in the reply shift register or in the handshake decode shows only at the end of the command, 32 frames after the start bit, as a wrong `err` or `rd_data`. Replies that are correct, missing or mismatched are each played for that reason. A latched request that is corrupted by a second request would show as a changed address field within the same command.

// File: rtl/cd_reg_seq_pkg.sv
`timescale 1ns/1ps
package cd_reg_seq_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} seq_st_t;

   // generator x^4 + x + 1 (x^4 implicit)
   localparam logic [3:0] CRC_POLY = 4'b0011;

   // MSB-first CRC over the low n bits of d, zero preset
   function automatic logic [3:0] crc4_msb(input logic [15:0] d, input int n);
      logic [3:0] c;
      logic       fb;
      c = '0;
      for (int i = 15; i >= 0; i--) begin
         if (i < n) begin
            fb = c[3] ^ d[i];
            c  = {c[2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
         end
      end
      return c;
   endfunction
endpackage

// File: rtl/cd_reg_seq_cmd.sv
`timescale 1ns/1ps
module cd_reg_seq_cmd #(
   parameter int ID_W     = 3,
   parameter int ADDR_W   = 7,
   parameter int DATA_W   = 8,
   parameter int SLAVE_ID = 0,
   parameter bit INV_CRC  = 1'b1,
   localparam int HDR_N   = ID_W + ADDR_W,
   localparam int PAY_N   = 3 + DATA_W,
   localparam int WORD_W  = 2 + HDR_N + 4 + PAY_N + 4 + 1
) (
   input  logic              is_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [WORD_W-1:0] word
);
   import cd_reg_seq_pkg::*;

   localparam logic [ID_W-1:0] ID_V = ID_W'(SLAVE_ID);

   if (HDR_N > 16 || PAY_N > 16) begin : g_bad_crc_span
      $error("CRC span exceeds 16 bits");
   end

   logic [DATA_W-1:0] data_eff;
   logic [15:0]       hdr_in, pay_in;
   logic [3:0]        crc_h_raw, crc_p_raw, crc_h, crc_p;

   assign data_eff  = is_wr ? wdata : '0;
   assign hdr_in    = 16'({ID_V, addr});
   assign pay_in    = 16'({~is_wr, is_wr, 1'b1, data_eff});
   assign crc_h_raw = crc4_msb(hdr_in, HDR_N);
   assign crc_p_raw = crc4_msb(pay_in, PAY_N);

   if (INV_CRC) begin : g_crc_inv
      assign crc_h = ~crc_h_raw;
      assign crc_p = ~crc_p_raw;
   end else begin : g_crc_true
      assign crc_h = crc_h_raw;
      assign crc_p = crc_p_raw;
   end

   // start, CTS, ID, addr, CRC, R, W, S, data, CRC, stop
   assign word = {2'b11, ID_V, addr, crc_h, ~is_wr, is_wr, 1'b1, data_eff, crc_p, 1'b0};
endmodule

// File: rtl/cd_reg_seq_quiet.sv
`timescale 1ns/1ps
module cd_reg_seq_quiet #(
   parameter int PRE    = 14,
   localparam int CW    = $clog2(PRE + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   output logic met
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                           cnt_q <= '0;
      else if (clr)                         cnt_q <= '0;
      else if (tick && cnt_q != CW'(PRE))   cnt_q <= cnt_q + 1'b1;
   end

   assign met = (cnt_q == CW'(PRE));

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(PRE));

   // R4
   quiet_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !met);
endmodule

// File: rtl/cd_reg_seq.sv
`timescale 1ns/1ps
module cd_reg_seq #(
   parameter int ID_W       = 3,
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 8,
   parameter int SLAVE_ID   = 0,
   parameter int PRE_FRAMES = 14,
   parameter int HS_LSB     = 12,
   parameter bit INV_CRC    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              cds_in,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              clk_idle_lvl,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rd_data
);
   import cd_reg_seq_pkg::*;

   localparam int WORD_W = 2 + ID_W + ADDR_W + 4 + 3 + DATA_W + 4 + 1;
   localparam int IDX_W  = $clog2(WORD_W);

   if (HS_LSB + 3 > WORD_W || HS_LSB < DATA_W) begin : g_bad_hs
      $error("handshake field does not fit the reply word");
   end

   seq_st_t           st_q;
   logic              wr_q, cdm_q, done_q, err_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q, rd_q;
   logic [IDX_W-1:0]  idx_q;
   logic [WORD_W-1:0] sh_q, sh_nx, cmd_w;
   logic [2:0]        hs;
   logic              ack, launch, q_tick, q_met;

   cd_reg_seq_cmd #(
      .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .SLAVE_ID(SLAVE_ID), .INV_CRC(INV_CRC)
   ) u_cmd (
      .is_wr(wr_q), .addr(addr_q), .wdata(data_q), .word(cmd_w)
   );

   assign launch = frame_stb && (st_q == ST_WAIT) && q_met;
   assign q_tick = frame_stb && (st_q != ST_SEND) && !launch;

   cd_reg_seq_quiet #(.PRE(PRE_FRAMES)) u_quiet (
      .clk(clk), .rst_n(rst_n), .tick(q_tick), .clr(launch), .met(q_met)
   );

   assign sh_nx = {sh_q[WORD_W-2:0], cds_in};
   assign hs    = sh_nx[HS_LSB+2:HS_LSB];
   assign ack   = wr_q ? (hs == 3'b011) : (hs == 3'b101);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         wr_q   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
         idx_q  <= '0;
         sh_q   <= '0;
         cdm_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         rd_q   <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (req_valid) begin
               wr_q   <= req_write;
               addr_q <= req_addr;
               data_q <= req_wdata;
               st_q   <= ST_WAIT;
            end
            ST_WAIT: if (launch) begin
               cdm_q <= cmd_w[WORD_W-1];
               idx_q <= IDX_W'(WORD_W - 1);
               sh_q  <= '0;
               st_q  <= ST_SEND;
            end
            ST_SEND: if (frame_stb) begin
               sh_q <= sh_nx;
               if (idx_q != '0) begin
                  cdm_q <= cmd_w[idx_q - 1'b1];
                  idx_q <= idx_q - 1'b1;
               end else begin
                  cdm_q  <= 1'b0;
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                  err_q  <= !ack;
                  if (ack && !wr_q) rd_q <= sh_nx[HS_LSB-1 -: DATA_W];
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign clk_idle_lvl = ~cdm_q;
   assign busy         = (st_q != ST_IDLE);
   assign done         = done_q;
   assign err          = err_q;
   assign rd_data      = rd_q;

   // R2
   bit_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> $stable(clk_idle_lvl));

   // R3
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_SEND) |-> clk_idle_lvl);

   // R4
   quiet_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && frame_stb && !q_met) |=> (st_q != ST_SEND));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   // R11
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> ($stable(addr_q) && $stable(wr_q) && $stable(data_q)));
endmodule

// File: tb/test_cd_reg_seq.sv
`timescale 1ns/1ps
module test_cd_reg_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_stb = 1'b0;
   logic       cds_in = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_write = 1'b0;
   logic [6:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       clk_idle_lvl, busy, done, err;
   logic [7:0] rd_data;

   int vecs = 0;
   int errs = 0;
   int quiet_b = 0;

   always #4 clk = ~clk;

   cd_reg_seq i_cd_reg_seq (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .cds_in(cds_in),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .clk_idle_lvl(clk_idle_lvl), .busy(busy),
      .done(done), .err(err), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] ref_crc(input logic [15:0] d, input int n);
      logic [3:0] c = 4'h0;
      logic top;
      for (int i = n - 1; i >= 0; i--) begin
         top = c[3];
         c = c << 1;
         if (top ^ d[i]) c = c ^ 4'h3;
      end
      return c;
   endfunction

   function automatic logic [31:0] ref_word(input bit wr, input logic [6:0] a, input logic [7:0] d);
      logic [7:0] de = wr ? d : 8'h00;
      logic [3:0] ch = ~ref_crc({6'b0, 3'b000, a}, 10);
      logic [3:0] cp = ~ref_crc({5'b0, ~wr, wr, 1'b1, de}, 11);
      return {2'b11, 3'b000, a, ch, ~wr, wr, 1'b1, de, cp, 1'b0};
   endfunction

   task automatic strobe(input logic b);
      @(negedge clk);
      frame_stb = 1'b1;
      cds_in    = b;
      @(negedge clk);
      frame_stb = 1'b0;
      cds_in    = 1'b0;
   endtask

   task automatic t_reset;
      chk(clk_idle_lvl === 1'b1, "R1", "line level", 32'(clk_idle_lvl), 1);
      chk(busy === 1'b0, "R1", "busy", 32'(busy), 0);
      chk(done === 1'b0, "R1", "done", 32'(done), 0);
      chk(err === 1'b0, "R1", "err", 32'(err), 0);
   endtask

   task automatic t_idle(input int n);
      for (int i = 0; i < n; i++) begin
         strobe(1'b0);
         quiet_b++;
         chk(clk_idle_lvl === 1'b1, "R3", "idle line", 32'(clk_idle_lvl), 1);
      end
   endtask

   task automatic t_xact(input string nm, input bit wr, input logic [6:0] a,
                         input logic [7:0] wd, input logic [2:0] hs,
                         input logic [7:0] rdat, input bit exp_err, input bit inject);
      logic [31:0] exp_w, got_w, resp;
      logic [7:0]  rd_before, rd_exp;
      int q0, waited, exp_wait;
      rd_before = rd_data;
      exp_w = ref_word(wr, a, wd);
      resp  = {17'b0, hs, rdat, 4'b0};
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy === 1'b1, "R11", {nm, " busy after request"}, 32'(busy), 1);
      q0 = quiet_b;
      waited = 0;
      do begin
         strobe(1'b0);
         waited++;
         if (clk_idle_lvl) quiet_b++;
      end while (clk_idle_lvl && waited < 40);
      exp_wait = (q0 >= 14) ? 1 : 15 - q0;
      chk(waited == exp_wait, "R4", {nm, " strobes to start bit"}, 32'(waited), 32'(exp_wait));
      quiet_b = 0;
      got_w = '0;
      got_w[31] = ~clk_idle_lvl;
      repeat (3) @(negedge clk);
      chk(clk_idle_lvl === 1'b0, "R2", {nm, " level held between strobes"}, 32'(clk_idle_lvl), 0);
      for (int k = 1; k <= 32; k++) begin
         if (inject && k == 10) begin
            @(negedge clk);
            req_valid = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~wd;
            @(negedge clk);
            req_valid = 1'b0;
         end
         strobe(resp[32-k]);
         if (k <= 31) begin
            got_w[31-k] = ~clk_idle_lvl;
            if (k == 31) chk(done === 1'b0, "R7", {nm, " done early"}, 32'(done), 0);
         end else begin
            rd_exp = (!wr && !exp_err) ? rdat : rd_before;
            chk(clk_idle_lvl === 1'b1, "R7", {nm, " line back high"}, 32'(clk_idle_lvl), 1);
            chk(done === 1'b1, "R7", {nm, " done"}, 32'(done), 1);
            chk(err === exp_err, exp_err ? "R9" : "R8", {nm, " err"}, 32'(err), 32'(exp_err));
            chk(rd_data === rd_exp, "R10", {nm, " rd_data"}, 32'(rd_data), 32'(rd_exp));
         end
      end
      chk(got_w === exp_w, "R5", {nm, " command word"}, got_w, exp_w);
      chk(got_w[19:16] === exp_w[19:16] && got_w[4:1] === exp_w[4:1], "R6",
          {nm, " CRC fields"}, {24'b0, got_w[19:16], got_w[4:1]}, {24'b0, exp_w[19:16], exp_w[4:1]});
      @(negedge clk);
      chk(done === 1'b0, "R7", {nm, " done pulse width"}, 32'(done), 0);
      chk(busy === 1'b0, "R11", {nm, " busy cleared"}, 32'(busy), 0);
   endtask

   initial begin
      fork
         begin
            repeat (4) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_idle(3);
            t_xact("read ok", 1'b0, 7'h7E, 8'h00, 3'd5, 8'hA5, 1'b0, 1'b0);
            t_xact("write ok", 1'b1, 7'h15, 8'h3C, 3'd3, 8'hFF, 1'b0, 1'b1);
            t_xact("no reply", 1'b0, 7'h40, 8'h00, 3'd0, 8'h00, 1'b1, 1'b0);
            t_idle(20);
            t_xact("wrong echo", 1'b0, 7'h01, 8'h00, 3'd3, 8'h77, 1'b1, 1'b0);
            t_xact("read two", 1'b0, 7'h2A, 8'h00, 3'd5, 8'h5A, 1'b0, 1'b0);
         end
         begin
            repeat (200000) @(posedge clk);
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule